// File: doc/BRIEF.md
# Clock Generator Lock Qualifier with Auto-Reset

This block sits beside an on-chip clock generator and turns its raw lock flag, which arrives with no timing relation to the reference clock, into a clean qualified lock level. The raw flag is first passed through a synchroniser clocked by the reference clock. A counter on the same clock then requires the synchronised flag to stay high for a number of consecutive cycles before the qualified output rises. That number is computed at elaboration from the worst-case settle time of the generator and the reference period, rounded up.

Once qualified, the output stays high while lock holds. A single low sample is treated as a glitch; two low samples in a row count as a true loss and drop the output. When the auto-reset option is on at that moment, the block drives a fixed-length reset pulse back into the generator, and it cannot issue another one until lock has been qualified again. A user reset, asynchronous and active high, clears the qualified output and holds the generator reset active for as long as it is applied.

Top module: `lock_qualifier`

## Requirements
- R1: While `rst_user` is high, `locked_q` is 0 and `gen_rst` is 1, taking effect without waiting for a clock edge; `gen_rst` returns to 0 once the reset is released and no pulse is running.
- R2: `lock_raw` reaches the qualification logic only through a synchroniser of `SYNC_STAGES` flops (default 2) clocked by `clk_ref`.
- R3: With the default two-stage synchroniser, if `lock_raw` is high at `GATE_CYCLES` + 2 consecutive rising edges starting from an unlocked state, `locked_q` rises after the last of those edges and not earlier.
- R4: A single low synchronised sample while counting restarts the count from zero, so a full `GATE_CYCLES` run of high samples is again required.
- R5: While `locked_q` is high, a synchronised lock that is low for one cycle only leaves `locked_q` high.
- R6: While `locked_q` is high, two consecutive low synchronised samples drop `locked_q` after the second of them.
- R7: If `autorst_en` is 1 at the edge where `locked_q` drops, `gen_rst` rises after that same edge and stays high for exactly `PULSE_CYCLES` cycles (default 8).
- R8: If `autorst_en` is 0 at the edge where `locked_q` drops, `gen_rst` stays 0.
- R9: While the auto-reset pulse is running no qualification count advances, and a new pulse can only follow a fresh qualification of lock.
- R10: `GATE_CYCLES` equals `MAX_LOCK_TIME_PS` divided by `REF_PERIOD_PS`, rounded up; the bench uses 155000 / 10000, giving 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; runs the synchroniser, the gate counter and the pulse timer |
| rst_user | input | 1 | Asynchronous user reset, active high |
| lock_raw | input | 1 | Unqualified lock flag from the generator, asynchronous |
| autorst_en | input | 1 | When 1, a loss of qualified lock fires a generator reset pulse |
| locked_q | output | 1 | Qualified lock level |
| gen_rst | output | 1 | Reset request to the generator: user reset or auto-reset pulse |

## Verification
The properties assume the user reset is applied before the first clock edge, since every clocked check is disabled under it, and that `autorst_en` is settled at the edge where a loss is recognised. The stimulus changes every input on the falling clock edge only, holds `lock_raw` low or high for whole cycles so glitch and loss cases are counted in exact synchronised samples, and asserts the mid-run reset away from any edge to expose its asynchronous effect.

// File: rtl/lkq_pkg.sv
package lkq_pkg;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_HELD = 1'b1
   } lkq_state_e;

   // Round-up division used to size the qualification window.
   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/lkq_sync.sv
module lkq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sr[0] <= 1'b0;
      else     sr[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst) sr[i] <= 1'b0;
         else     sr[i] <= sr[i-1];
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/lkq_gate.sv
module lkq_gate
   import lkq_pkg::*;
#(
   parameter int unsigned GATE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic lk,
   input  logic hold,
   output logic locked,
   output logic lost
);
   localparam int unsigned CW = $clog2(GATE_CYCLES + 1);

   lkq_state_e    state;
   logic [CW-1:0] cnt;
   logic          low_seen;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state    <= ST_HUNT;
         cnt      <= '0;
         low_seen <= 1'b0;
      end else begin
         case (state)
            ST_HUNT: begin
               low_seen <= 1'b0;
               if (!lk || hold) begin
                  cnt <= '0;
               end else if (cnt == CW'(GATE_CYCLES - 1)) begin
                  state <= ST_HELD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (lk) begin
                  low_seen <= 1'b0;
               end else if (low_seen) begin
                  state    <= ST_HUNT;
                  low_seen <= 1'b0;
               end else begin
                  low_seen <= 1'b1;
               end
            end
         endcase
      end
   end

   assign locked = (state == ST_HELD);
   assign lost   = (state == ST_HELD) && !lk && low_seen;
endmodule

// File: rtl/lkq_pulse.sv
module lkq_pulse #(
   parameter int unsigned PULSE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic busy
);
   if (PULSE_CYCLES == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_timer
      localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
      logic [PW-1:0] pc;
      logic          act;

      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            act <= 1'b0;
            pc  <= '0;
         end else if (fire) begin
            act <= 1'b1;
            pc  <= PW'(PULSE_CYCLES - 1);
         end else if (act) begin
            if (pc == '0) act <= 1'b0;
            else          pc  <= pc - 1'b1;
         end
      end

      assign busy = act;
   end
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
   import lkq_pkg::*;
#(
   parameter int unsigned REF_PERIOD_PS    = 10000,
   parameter int unsigned MAX_LOCK_TIME_PS = 155000,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter int unsigned PULSE_CYCLES     = 8
) (
   input  logic clk_ref,
   input  logic rst_user,
   input  logic lock_raw,
   input  logic autorst_en,
   output logic locked_q,
   output logic gen_rst
);
   // R10: qualification window from worst-case settle time, rounded up
   localparam int unsigned GATE_CYCLES = ceil_div(MAX_LOCK_TIME_PS, REF_PERIOD_PS);

   if (REF_PERIOD_PS == 0) begin : g_bad_period
      $error("lock_qualifier: REF_PERIOD_PS must be nonzero");
   end
   if (GATE_CYCLES < 1) begin : g_bad_gate
      $error("lock_qualifier: qualification window must be at least one cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lock_qualifier: SYNC_STAGES must be at least 2");
   end

   logic lk_s;
   logic busy;
   logic lost;
   logic fire;

   // R2: raw flag crosses into the reference domain
   lkq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk_ref),
      .rst (rst_user),
      .d   (lock_raw),
      .q   (lk_s)
   );

   lkq_gate #(.GATE_CYCLES(GATE_CYCLES)) gate_i (
      .clk    (clk_ref),
      .rst    (rst_user),
      .lk     (lk_s),
      .hold   (busy),
      .locked (locked_q),
      .lost   (lost)
   );

   assign fire = lost && autorst_en;

   lkq_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) pulse_i (
      .clk  (clk_ref),
      .rst  (rst_user),
      .fire (fire),
      .busy (busy)
   );

   assign gen_rst = rst_user || busy;
endmodule

// File: rtl/lock_qualifier_chk.sv
module lock_qualifier_chk #(
   parameter int unsigned GATE_CYCLES  = 16,
   parameter int unsigned PULSE_CYCLES = 8
) (
   input logic clk_ref,
   input logic rst_user,
   input logic autorst_en,
   input logic locked_q,
   input logic gen_rst,
   input logic lk_sync
);
   logic [31:0] hi_run;
   logic [31:0] plen;
   logic        lk_d1, lk_d2;
   logic        seen;

   always_ff @(posedge clk_ref or posedge rst_user) begin
      if (rst_user) begin
         hi_run <= '0;
         plen   <= '0;
         lk_d1  <= 1'b0;
         lk_d2  <= 1'b0;
         seen   <= 1'b0;
      end else begin
         seen  <= 1'b1;
         lk_d1 <= lk_sync;
         lk_d2 <= lk_d1;
         if (!lk_sync)                hi_run <= '0;
         else if (hi_run < GATE_CYCLES) hi_run <= hi_run + 1;
         if (gen_rst) plen <= plen + 1;
         else         plen <= '0;
      end
   end

   assert_qual_run_R3: assert property (@(posedge clk_ref) disable iff (rst_user)
      $rose(locked_q) |-> (hi_run >= GATE_CYCLES));

   // R5 and R6: a drop needs two low synchronised samples in a row
   assert_two_low_R6: assert property (@(posedge clk_ref) disable iff (rst_user)
      $fell(locked_q) |-> (!lk_d1 && !lk_d2));

   assert_pulse_cause_R7: assert property (@(posedge clk_ref) disable iff (rst_user)
      $rose(gen_rst) |-> ($fell(locked_q) && $past(autorst_en)));

   assert_pulse_len_R7: assert property (@(posedge clk_ref) disable iff (rst_user)
      (seen && $fell(gen_rst)) |-> (plen == PULSE_CYCLES));

   assert_no_qual_in_pulse_R9: assert property (@(posedge clk_ref) disable iff (rst_user)
      $rose(locked_q) |-> !$past(gen_rst));
endmodule

bind lock_qualifier lock_qualifier_chk #(
   .GATE_CYCLES  (GATE_CYCLES),
   .PULSE_CYCLES (PULSE_CYCLES)
) chk_i (
   .clk_ref    (clk_ref),
   .rst_user   (rst_user),
   .autorst_en (autorst_en),
   .locked_q   (locked_q),
   .gen_rst    (gen_rst),
   .lk_sync    (lk_s)
);

// File: tb/lock_qualifier_tb_top.sv
module lock_qualifier_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int GATE       = 16;   // R10: ceil(155000 / 10000)
   localparam int PULSE      = 8;

   logic clk = 1'b0;
   logic rst_user = 1'b1;
   logic lock_raw = 1'b0;
   logic autorst_en = 1'b0;
   logic locked_q, gen_rst;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_q[$] = '{0, 0};
   int m_run = 0, m_low = 0, m_pulse = 0;
   bit m_locked = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lock_qualifier #(
      .REF_PERIOD_PS(10000), .MAX_LOCK_TIME_PS(155000),
      .SYNC_STAGES(2), .PULSE_CYCLES(PULSE)
   ) dut_i (
      .clk_ref(clk), .rst_user(rst_user), .lock_raw(lock_raw),
      .autorst_en(autorst_en), .locked_q(locked_q), .gen_rst(gen_rst)
   );

   always @(posedge clk) begin
      if (rst_user) begin
         m_q = '{0, 0};
         m_run = 0; m_low = 0; m_pulse = 0; m_locked = 0;
      end else begin
         int lk;
         bit start;
         lk = m_q.pop_front();
         m_q.push_back(int'(lock_raw));
         start = 0;
         if (!m_locked) begin
            if (lk == 0 || m_pulse > 0) m_run = 0;
            else begin
               m_run++;
               if (m_run == GATE) begin m_locked = 1; m_run = 0; end
            end
         end else begin
            if (lk == 0) begin
               m_low++;
               if (m_low == 2) begin
                  m_locked = 0; m_low = 0;
                  start = autorst_en;
               end
            end else m_low = 0;
         end
         if (m_pulse > 0) m_pulse--;
         if (start) m_pulse = PULSE;
      end
   end

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   task automatic check(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check(cur_req, "locked_q vs model", locked_q, m_locked);
      check(cur_req, "gen_rst vs model", gen_rst, rst_user | (m_pulse > 0));
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_up();
      end
   end

   initial begin
      int k;
      cur_req = "R1";
      ticks(3);
      check("R1", "locked_q in reset", locked_q, 1'b0);
      check("R1", "gen_rst in reset", gen_rst, 1'b1);
      rst_user = 1'b0;
      ticks(2);
      check("R1", "gen_rst after release", gen_rst, 1'b0);

      // R2/R3: latency of the synchroniser plus the gate window
      cur_req = "R3";
      lock_raw = 1'b1;
      k = 0;
      while (locked_q !== 1'b1 && k < 60) begin tick(); k++; end
      check("R3", "lock latency is GATE+2 edges", (k == GATE + 2), 1'b1);
      if (k != GATE + 2) $display("FAIL R3 latency: actual %0d expected %0d", k, GATE + 2);

      // R5: single low sample is a glitch
      cur_req = "R5";
      lock_raw = 1'b0; tick(); lock_raw = 1'b1;
      ticks(6);
      check("R5", "locked_q after one-cycle drop", locked_q, 1'b1);

      // R6/R8: real loss without auto-reset
      cur_req = "R8";
      autorst_en = 1'b0;
      lock_raw = 1'b0;
      ticks(4);
      check("R6", "locked_q after two low samples", locked_q, 1'b0);
      check("R8", "gen_rst with auto-reset off", gen_rst, 1'b0);
      ticks(3);

      // R4: restart on a low sample during counting
      cur_req = "R4";
      lock_raw = 1'b1; ticks(8);
      lock_raw = 1'b0; tick();
      lock_raw = 1'b1; ticks(GATE);
      check("R4", "still unlocked after restart", locked_q, 1'b0);
      ticks(4);
      check("R4", "locked after full window", locked_q, 1'b1);

      // R7/R9: loss with auto-reset, lock flag high during the pulse
      cur_req = "R7";
      autorst_en = 1'b1;
      lock_raw = 1'b0; ticks(3);
      lock_raw = 1'b1;
      k = 0;
      for (int i = 0; i < 30; i++) begin tick(); if (gen_rst) k++; end
      check("R7", "pulse length is PULSE", (k == PULSE), 1'b1);
      if (k != PULSE) $display("FAIL R7 pulse: actual %0d expected %0d", k, PULSE);
      cur_req = "R9";
      k = 0;
      while (locked_q !== 1'b1 && k < 60) begin tick(); k++; end
      check("R9", "relocked after pulse", locked_q, 1'b1);
      ticks(3);
      lock_raw = 1'b0; ticks(4);
      check("R9", "second pulse after relock", gen_rst, 1'b1);
      ticks(12);
      check("R9", "no pulse without relock", gen_rst, 1'b0);

      // R1: asynchronous reset while locked
      cur_req = "R1";
      lock_raw = 1'b1; ticks(GATE + 4);
      check("R1", "locked before async reset", locked_q, 1'b1);
      #2 rst_user = 1'b1;
      #1;
      check("R1", "locked_q cleared asynchronously", locked_q, 1'b0);
      check("R1", "gen_rst raised asynchronously", gen_rst, 1'b1);
      tick();
      rst_user = 1'b0;
      ticks(5);
      finish_up();
   end
endmodule